// File: doc/BRIEF.md
# UART FIFO Status, Ready Pins and Trigger Interrupts

This block keeps the transmit and receive character queues of one UART channel and turns their fill levels into the signals a DMA engine and an interrupt controller use. The host pushes characters for transmission with a byte write strobe and pops received characters with a read strobe. A serializer-side port stands in for the shift registers: it pops characters from the transmit queue and pushes characters into the receive queue.

A byte-wide control register write turns queueing on, flushes either queue and picks the trigger thresholds and the DMA signalling style. With queueing off, each direction holds one character. With queueing on, each direction holds 64. The two active-low ready pins behave in one of two ways. In single-transfer signalling they report one character or one free slot. In block signalling they follow the queue limits and the receive threshold. The receive queue keeps accepting characters past its threshold until it is full. Any character that arrives after that is dropped and marked as an overrun.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset, queueing is off, signalling style is single-transfer, both threshold codes are 00 and both queues are empty: txrdy_n=0, rxrdy_n=1, tx_irq=1, rx_irq=0, rx_overrun=0, ser_tx_valid=0.
- R2: A control write stores bit 0 as queue enable, bit 3 as block-signalling select, bits 5:4 as transmit threshold code and bits 7:6 as receive threshold code. Bit 1 empties the receive queue and clears rx_overrun. Bit 2 empties the transmit queue. Bits 1 and 2 are not stored and take effect at the clock edge of the write.
- R3: Capacity is 64 characters per queue with queueing on and 1 with it off. A host write into a full transmit queue is ignored, and the queued data are unchanged.
- R4: A serializer push into a full receive queue is dropped and sets rx_overrun. rx_overrun stays set until a receive flush or reset.
- R5: In single-transfer signalling, txrdy_n is 0 exactly when the transmit queue is empty.
- R6: In single-transfer signalling, rxrdy_n is 0 exactly when the receive queue holds at least one character.
- R7: In block signalling (queueing on, bit 3 = 1), txrdy_n is 0 exactly when the transmit queue holds fewer than 64 characters.
- R8: In block signalling, rxrdy_n is 0 exactly when the receive count is strictly greater than the receive threshold.
- R9: With queueing on, rx_irq is 1 when the receive count is at least the threshold selected by code 00/01/10/11 = 8/16/56/60. With queueing off, rx_irq is 1 when a character is held.
- R10: With queueing on, tx_irq is 1 when the transmit count is below the threshold selected by code 00/01/10/11 = 8/16/32/56. With queueing off, tx_irq is 1 when the transmit holding slot is empty.
- R11: Characters leave each queue in arrival order. A control write that changes the enable bit also empties both queues.
- R12: With queueing off, the block-signalling bit has no effect, and the pins follow single-transfer signalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| thr_wr | input | 1 | Host write of a transmit character |
| thr_wdata | input | 8 | Transmit character from host |
| rhr_rd | input | 1 | Host read (pop) of a receive character |
| rhr_rdata | output | 8 | Oldest receive character |
| ser_tx_pop | input | 1 | Serializer takes the oldest transmit character |
| ser_tx_data | output | 8 | Oldest transmit character |
| ser_tx_valid | output | 1 | Transmit queue not empty |
| ser_rx_push | input | 1 | Serializer delivers a received character |
| ser_rx_data | input | 8 | Received character |
| txrdy_n | output | 1 | Transmit ready, active low |
| rxrdy_n | output | 1 | Receive ready, active low |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The assertions check four things on every cycle. Each queue count stays within the present capacity and moves only in the direction its strobes allow. A flush leaves the count at zero. rx_overrun rises after a dropped character and stays set until a flush. A full transmit queue in block signalling keeps txrdy_n high until something pops it. The threshold mapping for each code and the exact boundary where the pins and interrupts switch can only be shown by the bench's scenarios. The same holds for data order, the ignored write into a full queue, and the difference between the two signalling styles at equal fill levels.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  function automatic int rx_trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int tx_trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/uart_fcr_reg.sv
module uart_fcr_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic       fifo_en,
  output logic       blk_mode,
  output logic [1:0] tx_code,
  output logic [1:0] rx_code,
  output logic       clr_tx,
  output logic       clr_rx
);
  logic       fifo_en_nxt, blk_mode_nxt;
  logic [1:0] tx_code_nxt, rx_code_nxt;
  logic       en_change;

  always_comb begin
    en_change    = ctl_wr && (ctl_wdata[0] != fifo_en);
    clr_rx       = ctl_wr && (ctl_wdata[1] || en_change);
    clr_tx       = ctl_wr && (ctl_wdata[2] || en_change);
    fifo_en_nxt  = fifo_en;
    blk_mode_nxt = blk_mode;
    tx_code_nxt  = tx_code;
    rx_code_nxt  = rx_code;
    if (ctl_wr) begin
      fifo_en_nxt  = ctl_wdata[0];
      blk_mode_nxt = ctl_wdata[3];
      tx_code_nxt  = ctl_wdata[5:4];
      rx_code_nxt  = ctl_wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      blk_mode <= 1'b0;
      tx_code  <= 2'd0;
      rx_code  <= 2'd0;
    end else begin
      fifo_en  <= fifo_en_nxt;
      blk_mode <= blk_mode_nxt;
      tx_code  <= tx_code_nxt;
      rx_code  <= rx_code_nxt;
    end
  end
endmodule

// File: rtl/uart_stat_fifo.sv
module uart_stat_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, rd_ptr_nxt, wr_ptr_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          do_push, do_pop;

  always_comb begin
    full    = single ? (count != '0) : (count == CW'(DEPTH));
    empty   = (count == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    drop    = push && full && !clr;
    head    = mem[rd_ptr];
    if (clr) begin
      rd_ptr_nxt = '0;
      wr_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      rd_ptr_nxt = rd_ptr + AW'(do_pop);
      wr_ptr_nxt = wr_ptr + AW'(do_push);
      cnt_nxt    = count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_nxt;
      wr_ptr <= wr_ptr_nxt;
      count  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= push_data;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (single ? CW'(1) : CW'(DEPTH)) || $past(!single));
  assert_no_growth_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !push) |=> (count <= $past(count)));
  assert_no_shrink_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pop) |=> (count >= $past(count)));
  assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic [7:0]   ctl_wdata,
  input  logic         thr_wr,
  input  logic [W-1:0] thr_wdata,
  input  logic         rhr_rd,
  output logic [W-1:0] rhr_rdata,
  input  logic         ser_tx_pop,
  output logic [W-1:0] ser_tx_data,
  output logic         ser_tx_valid,
  input  logic         ser_rx_push,
  input  logic [W-1:0] ser_rx_data,
  output logic         txrdy_n,
  output logic         rxrdy_n,
  output logic         tx_irq,
  output logic         rx_irq,
  output logic         rx_overrun
);
  import uart_fifo_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic          fifo_en, blk_mode, clr_tx, clr_rx, blk_sig;
  logic [1:0]    tx_code, rx_code;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_thr, rx_thr;
  logic          tx_full, tx_empty, rx_full, rx_empty, tx_drop, rx_drop;
  logic          ovr_nxt;

  uart_fcr_reg u_fcr (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .fifo_en(fifo_en), .blk_mode(blk_mode), .tx_code(tx_code),
    .rx_code(rx_code), .clr_tx(clr_tx), .clr_rx(clr_rx)
  );

  uart_stat_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr_tx), .single(!fifo_en),
    .push(thr_wr), .push_data(thr_wdata), .pop(ser_tx_pop),
    .head(ser_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .drop(tx_drop)
  );

  uart_stat_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr_rx), .single(!fifo_en),
    .push(ser_rx_push), .push_data(ser_rx_data), .pop(rhr_rd),
    .head(rhr_rdata), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .drop(rx_drop)
  );

  always_comb begin
    tx_thr       = CW'(tx_trig_level(tx_code));
    rx_thr       = CW'(rx_trig_level(rx_code));
    blk_sig      = fifo_en && blk_mode;
    ser_tx_valid = !tx_empty;
    txrdy_n      = blk_sig ? tx_full : !tx_empty;
    rxrdy_n      = blk_sig ? !(rx_cnt > rx_thr) : rx_empty;
    tx_irq       = fifo_en ? (tx_cnt < tx_thr) : tx_empty;
    rx_irq       = fifo_en ? (rx_cnt >= rx_thr) : !rx_empty;
    ovr_nxt      = clr_rx ? 1'b0 : (rx_overrun || rx_drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_overrun <= 1'b0;
    else        rx_overrun <= ovr_nxt;
  end

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !clr_rx) |=> rx_overrun);
  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_rd_unused(rhr_rd)) |=> rx_overrun);
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_sig && txrdy_n && !ser_tx_pop && !ctl_wr) |=> txrdy_n);
  assert_rx_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1]) |=> (!rx_irq && rxrdy_n && !rx_overrun));

  function automatic logic rx_rd_unused(input logic rd);
    return 1'b0 & rd;
  endfunction

  logic unused_ok;
  assign unused_ok = tx_drop & rx_full;
endmodule

// File: tb/tb_uart_fifo_dma.sv
module tb_uart_fifo_dma;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 0, thr_wr = 0, rhr_rd = 0, ser_tx_pop = 0, ser_rx_push = 0;
  logic [7:0] ctl_wdata = 0, thr_wdata = 0, ser_rx_data = 0;
  logic [7:0] rhr_rdata, ser_tx_data;
  logic       ser_tx_valid, txrdy_n, rxrdy_n, tx_irq, rx_irq, rx_overrun;
  int n_tests = 0, n_fail = 0;

  localparam int RXT [4] = '{8, 16, 56, 60};
  localparam int TXT [4] = '{8, 16, 32, 56};

  always #4 clk = ~clk;

  uart_fifo_dma dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .rhr_rd(rhr_rd), .rhr_rdata(rhr_rdata),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .txrdy_n(txrdy_n),
    .rxrdy_n(rxrdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wr = 1; ctl_wdata = d; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic wr_tx(input logic [7:0] d);
    thr_wr = 1; thr_wdata = d; @(negedge clk); thr_wr = 0;
  endtask
  task automatic push_rx(input logic [7:0] d);
    ser_rx_push = 1; ser_rx_data = d; @(negedge clk); ser_rx_push = 0;
  endtask
  task automatic pop_tx(output logic [7:0] d);
    d = ser_tx_data; ser_tx_pop = 1; @(negedge clk); ser_tx_pop = 0;
  endtask
  task automatic rd_rx(output logic [7:0] d);
    d = rhr_rdata; rhr_rd = 1; @(negedge clk); rhr_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 txrdy_n", txrdy_n, 0);
    check("R1 rxrdy_n", rxrdy_n, 1);
    check("R1 tx_irq", tx_irq, 1);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 overrun", rx_overrun, 0);
    check("R1 valid", ser_tx_valid, 0);

    // queueing off: single holding slot
    wr_tx(8'hA1);
    check("R5 txrdy_n after write", txrdy_n, 1);
    check("R10 tx_irq held", tx_irq, 0);
    wr_tx(8'hA2);
    pop_tx(d);
    check("R3 ignored write keeps data", d, 8'hA1);
    check("R3 slot empty after pop", ser_tx_valid, 0);
    check("R5 txrdy_n empty", txrdy_n, 0);
    push_rx(8'h51);
    check("R6 rxrdy_n held", rxrdy_n, 0);
    check("R9 rx_irq held", rx_irq, 1);
    push_rx(8'h52);
    check("R4 overrun single", rx_overrun, 1);
    // R12: block bit with queueing off keeps single-transfer pins
    wr_ctl(8'h08);
    check("R12 rxrdy_n", rxrdy_n, 0);
    check("R4 overrun sticky", rx_overrun, 1);
    rd_rx(d);
    check("R4 kept first char", d, 8'h51);
    check("R12 rxrdy_n empty", rxrdy_n, 1);
    wr_tx(8'h10);
    check("R12 txrdy_n", txrdy_n, 1);

    // enable: clears both queues (R11)
    wr_ctl(8'h01);
    check("R11 enable flushes tx", ser_tx_valid, 0);
    check("R11 enable clears overrun", rx_overrun, 0);

    // table walk in block signalling
    for (int k = 0; k < 4; k++) begin
      wr_ctl(8'(k << 6) | 8'(k << 4) | 8'h0F);
      for (int i = 0; i < RXT[k] - 1; i++) push_rx(8'(i));
      check($sformatf("R9 rx_irq below code %0d", k), rx_irq, 0);
      check("R8 rxrdy_n below", rxrdy_n, 1);
      push_rx(8'hFF);
      check($sformatf("R9 rx_irq at code %0d", k), rx_irq, 1);
      check("R8 rxrdy_n at thr", rxrdy_n, 1);
      push_rx(8'hFF);
      check("R8 rxrdy_n above thr", rxrdy_n, 0);
      check("R10 tx_irq empty", tx_irq, 1);
      for (int i = 0; i < TXT[k] - 1; i++) wr_tx(8'(i));
      check($sformatf("R10 tx_irq below code %0d", k), tx_irq, 1);
      wr_tx(8'(TXT[k] - 1));
      check($sformatf("R10 tx_irq at code %0d", k), tx_irq, 0);
      for (int i = TXT[k]; i < 63; i++) wr_tx(8'(i));
      check("R7 txrdy_n 63", txrdy_n, 0);
      wr_tx(8'd63);
      check("R7 txrdy_n full", txrdy_n, 1);
      wr_tx(8'hEE);
      bad = 0;
      for (int i = 0; i < 64; i++) begin
        pop_tx(d);
        if (d != 8'(i)) bad++;
      end
      check("R11 tx order", bad, 0);
      check("R3 full write ignored", ser_tx_valid, 0);
    end

    // single-transfer with queueing on, keep data until flush
    wr_ctl(8'h07);
    wr_tx(8'h33);
    check("R5 txrdy_n fifo", txrdy_n, 1);
    wr_tx(8'h34);
    check("R5 tx_irq two", tx_irq, 1);
    push_rx(8'h44);
    check("R6 rxrdy_n one", rxrdy_n, 0);
    check("R9 rx_irq one", rx_irq, 0);
    // R2 flush tx only
    wr_ctl(8'h05);
    check("R2 tx flushed", txrdy_n, 0);
    check("R2 rx untouched", rxrdy_n, 0);
    rd_rx(d);
    check("R6 rx data", d, 8'h44);
    check("R6 rxrdy_n empty", rxrdy_n, 1);

    // R4 overrun with queueing on
    for (int i = 0; i < 64; i++) push_rx(8'(i + 100));
    check("R4 no overrun at 64", rx_overrun, 0);
    push_rx(8'h00);
    check("R4 overrun set", rx_overrun, 1);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd_rx(d);
      if (d != 8'(i + 100)) bad++;
    end
    check("R11 rx order", bad, 0);
    check("R4 overrun sticky after drain", rx_overrun, 1);
    wr_ctl(8'h03);
    check("R2 rx flush clears overrun", rx_overrun, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule